// File: doc/BRIEF.md
# Sticky Interrupt Event Collector for a Clock-Synchronisation Controller

The block watches the live status of a clock-synchronisation controller and turns status changes into eight event flags. These are reference qualification, cross-couple reference activity, loop mode, active reference choice, signal loss and lock loss. Each flag is held in a sticky event register until software reads that register. A single read clears every flag. A per-bit enable register decides which held flags may pull the active-low interrupt pin. A flag is recorded even when its enable bit is 0, so software can poll for it.

Two alarm flags change behaviour with the control mode. Under manual control, the signal-loss and lock-loss flags stop latching and instead follow the live alarm levels, one clock later. Under automatic control they latch on a rising alarm. A lock-loss rise is not reported while the active reference is being switched automatically. This suppression covers the switch cycle and a fixed holdoff window after it.

The block samples its status inputs in the clock domain of the register interface. The event register is presented on a read-data port; the read strobe marks the cycle in which software takes that value.

Top module: `sync_evt_irq`

## Requirements
- R1: Event bit positions, each set on the clock edge after its cause (automatic control): bit 0 when any `ref_ok` bit falls 1->0; bit 1 on a `better_ref_p` pulse; bit 2 when `xref_active` falls; bit 3 when `xref_active` rises; bit 4 when `dpll_mode` changes value; bit 5 when `active_sel` changes value; bit 6 when `los` rises; bit 7 when `lol` rises.
- R2: A held event bit drives `irq_n` only while its enable bit is 1; the event bit is recorded and visible on `evt_o` whether or not it is enabled.
- R3: An `evt_rd` cycle clears all latched event bits at that clock edge.
- R4: Outside a read, a set event bit stays set.
- R5: An event that arises in the same cycle as `evt_rd` is kept: it is set after that edge.
- R6: While `manual_mode` is 1, bit 6 equals the value `los` had one edge earlier, and bit 7 equals the value `lol` had one edge earlier. A read does not clear them.
- R7: Bit 5 is set only under automatic control. A `lol` rise is not recorded under automatic control in the cycle `active_sel` changes, or in the following `HOLDOFF` cycles (default 16). A rise 18 cycles after the switch is recorded.
- R8: `irq_n` is 1 exactly when the bitwise AND of the event and enable registers is zero.
- R8 (reset part): After reset both the event and enable registers are 0 and `irq_n` is 1.
- R9: On the first clock edge after reset the previous-value registers load the inputs and raise no event. Input levels that were already present through reset therefore produce no flags.
- R10: Under manual control, a loop mode change together with a rising `los` sets bit 4 and bit 6 in the same edge (event value 0x50).
- R11: An `en_wr` cycle loads `en_wdata` into the enable register at that edge, and `irq_n` reflects the new enables immediately after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| manual_mode | input | 1 | 1 = manual control, 0 = automatic control |
| ref_ok | input | N_REF | Per-reference availability level |
| better_ref_p | input | 1 | One-cycle pulse: higher-priority reference became available |
| xref_active | input | 1 | Cross-couple reference activity level |
| dpll_mode | input | MODE_W | Current loop operating mode code |
| active_sel | input | SEL_W | Index of the active reference |
| los | input | 1 | Live loss-of-signal alarm on the active reference |
| lol | input | 1 | Live loss-of-lock alarm |
| evt_rd | input | 1 | Event register read strobe (clears on this edge) |
| evt_o | output | 8 | Event register contents |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
The assertions assume that the status inputs are synchronous to `clk` and settle between edges. They also assume that `better_ref_p` is a single-cycle pulse and that `manual_mode` is held steady across the cycles being related. The bench changes every input only at the falling clock edge. It holds `manual_mode` constant within each stretch of rows and moves the alarms as whole levels, never glitches. Rows that switch the active reference keep the alarm levels unchanged in the same cycle, except where the lock-loss suppression window itself is under test.

// File: rtl/sei_pkg.sv
`timescale 1ns/1ps
package sei_pkg;
  localparam int EVT_W = 8;
  localparam int B_REF_LOST   = 0;
  localparam int B_BETTER_REF = 1;
  localparam int B_XREF_LOST  = 2;
  localparam int B_XREF_BACK  = 3;
  localparam int B_MODE_CHG   = 4;
  localparam int B_SEL_CHG    = 5;
  localparam int B_LOS        = 6;
  localparam int B_LOL        = 7;
  typedef logic [EVT_W-1:0] evt_vec_t;
endpackage

// File: rtl/sei_detect.sv
`timescale 1ns/1ps
module sei_detect
  import sei_pkg::*;
#(
  parameter int N_REF   = 4,
  parameter int MODE_W  = 3,
  parameter int SEL_W   = 2,
  parameter int HOLDOFF = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              manual,
  input  logic [N_REF-1:0]  ref_ok,
  input  logic              better_ref,
  input  logic              xref_act,
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic              los,
  input  logic              lol,
  output evt_vec_t          hit
);
  localparam int CNT_W = (HOLDOFF < 1) ? 1 : $clog2(HOLDOFF + 1);

  logic [N_REF-1:0]  ref_prev_q;
  logic [N_REF-1:0]  ref_fall;
  logic              xref_prev_q;
  logic [MODE_W-1:0] mode_prev_q;
  logic [SEL_W-1:0]  sel_prev_q;
  logic              los_prev_q;
  logic              lol_prev_q;
  logic              primed_q;
  logic [CNT_W-1:0]  hold_q;
  logic [CNT_W-1:0]  hold_d;
  logic              hold_en;
  logic              sw_auto;
  logic              suppress;
  evt_vec_t          raw;

  // per-reference falling-edge detectors
  genvar g;
  for (g = 0; g < N_REF; g++) begin : g_ref
    assign ref_fall[g] = ref_prev_q[g] & ~ref_ok[g];
  end

  assign sw_auto  = primed_q & ~manual & (sel != sel_prev_q);
  assign suppress = sw_auto | (hold_q != '0);

  always_comb begin
    raw               = '0;
    raw[B_REF_LOST]   = |ref_fall;
    raw[B_BETTER_REF] = better_ref;
    raw[B_XREF_LOST]  = xref_prev_q & ~xref_act;
    raw[B_XREF_BACK]  = ~xref_prev_q & xref_act;
    raw[B_MODE_CHG]   = (mode != mode_prev_q);
    raw[B_SEL_CHG]    = sw_auto;
    raw[B_LOS]        = los & ~los_prev_q;
    raw[B_LOL]        = lol & ~lol_prev_q & ~suppress;
    hit               = primed_q ? raw : '0;
  end

  // holdoff window next state
  always_comb begin
    hold_en = sw_auto | (hold_q != '0);
    if (sw_auto)
      hold_d = CNT_W'(HOLDOFF);
    else if (hold_q != '0)
      hold_d = hold_q - 1'b1;
    else
      hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev_q  <= '0;
      xref_prev_q <= 1'b0;
      mode_prev_q <= '0;
      sel_prev_q  <= '0;
      los_prev_q  <= 1'b0;
      lol_prev_q  <= 1'b0;
      primed_q    <= 1'b0;
    end else begin
      ref_prev_q  <= ref_ok;
      xref_prev_q <= xref_act;
      mode_prev_q <= mode;
      sel_prev_q  <= sel;
      los_prev_q  <= los;
      lol_prev_q  <= lol;
      primed_q    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= '0;
    else if (hold_en)
      hold_q <= hold_d;
  end

  // R7: no lock-loss event while the holdoff window is open
  a_r7_lol_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) |-> !hit[B_LOL]);

  // R7: an automatic switch cycle never reports lock loss
  a_r7_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !manual && sel != sel_prev_q) |-> !hit[B_LOL]);

  // R9: nothing is reported before the previous-value registers are loaded
  a_r9_primed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> (hit == '0));
endmodule

// File: rtl/sei_latch.sv
`timescale 1ns/1ps
module sei_latch
  import sei_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     manual,
  input  evt_vec_t hit,
  input  logic     rd_clr,
  input  logic     los,
  input  logic     lol,
  output evt_vec_t evt_q
);
  evt_vec_t nxt;
  logic     upd;

  genvar g;
  for (g = 0; g < EVT_W; g++) begin : g_bit
    if (g == B_LOS || g == B_LOL) begin : g_mirror
      logic live;
      assign live   = (g == B_LOS) ? los : lol;
      assign nxt[g] = manual ? live : ((evt_q[g] & ~rd_clr) | hit[g]);
    end else begin : g_sticky
      assign nxt[g] = (evt_q[g] & ~rd_clr) | hit[g];
    end
  end

  assign upd = rd_clr | (|hit) | manual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      evt_q <= '0;
    else if (upd)
      evt_q <= nxt;
  end

  // R3: a read with no concurrent event empties the register
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && hit == '0 && !manual) |=> (evt_q == '0));

  // R4: without a read, held flags remain
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !manual) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R1, R5: every detected event lands, even beside a read
  a_r5_hit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !manual |=> ((evt_q & $past(hit)) == $past(hit)));

  // R6: manual control mirrors the live alarms one edge later
  a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    manual |=> (evt_q[B_LOS] == $past(los) && evt_q[B_LOL] == $past(lol)));
endmodule

// File: rtl/sei_gate.sv
`timescale 1ns/1ps
module sei_gate
  import sei_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t evt,
  input  logic     en_wr,
  input  evt_vec_t en_wdata,
  output logic     irq_n
);
  evt_vec_t en_q;
  evt_vec_t en_d;

  always_comb begin
    en_d = en_q;
    if (en_wr)
      en_d = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '0;
    else if (en_wr)
      en_q <= en_d;
  end

  assign irq_n = ~|(evt & en_q);

  // R2, R11: writing all-zero enables releases the pin on the next cycle
  a_r11_disable_all: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && en_wdata == '0) |=> irq_n);

  // R8: with no held event the pin is never asserted
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |-> irq_n);
endmodule

// File: rtl/sync_evt_irq.sv
`timescale 1ns/1ps
module sync_evt_irq
  import sei_pkg::*;
#(
  parameter int N_REF   = 4,
  parameter int MODE_W  = 3,
  parameter int SEL_W   = (N_REF > 1) ? $clog2(N_REF) : 1,
  parameter int HOLDOFF = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              manual_mode,
  input  logic [N_REF-1:0]  ref_ok,
  input  logic              better_ref_p,
  input  logic              xref_active,
  input  logic [MODE_W-1:0] dpll_mode,
  input  logic [SEL_W-1:0]  active_sel,
  input  logic              los,
  input  logic              lol,
  input  logic              evt_rd,
  output logic [7:0]        evt_o,
  input  logic              en_wr,
  input  logic [7:0]        en_wdata,
  output logic              irq_n
);
  evt_vec_t hit;
  evt_vec_t evt_q;

  sei_detect #(
    .N_REF(N_REF), .MODE_W(MODE_W), .SEL_W(SEL_W), .HOLDOFF(HOLDOFF)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .manual(manual_mode), .ref_ok(ref_ok),
    .better_ref(better_ref_p), .xref_act(xref_active), .mode(dpll_mode),
    .sel(active_sel), .los(los), .lol(lol), .hit(hit)
  );

  sei_latch u_latch (
    .clk(clk), .rst_n(rst_n), .manual(manual_mode), .hit(hit),
    .rd_clr(evt_rd), .los(los), .lol(lol), .evt_q(evt_q)
  );

  sei_gate u_gate (
    .clk(clk), .rst_n(rst_n), .evt(evt_q), .en_wr(en_wr),
    .en_wdata(en_wdata), .irq_n(irq_n)
  );

  assign evt_o = evt_q;
endmodule

// File: tb/sim_sync_evt_irq.sv
`timescale 1ns/1ps
module sim_sync_evt_irq;
  typedef struct packed {
    logic       man;
    logic [3:0] rok;
    logic       xr;
    logic [2:0] md;
    logic [1:0] sl;
    logic       ls;
    logic       ll;
    logic       bt;
    logic       rd;
    logic       ew;
    logic [7:0] ewd;
    logic [7:0] xe;
    logic       xi;
  } row_t;

  localparam int NROW = 19;
  localparam row_t TBL [NROW] = '{
    '{1'b0,4'h0,1'b0,3'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hFF,8'h00,1'b1},
    '{1'b0,4'hF,1'b0,3'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b1},
    '{1'b0,4'hD,1'b0,3'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h01,1'b0},
    '{1'b0,4'hD,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h09,1'b0},
    '{1'b0,4'hD,1'b0,3'd0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,8'h04,1'b0},
    '{1'b0,4'hD,1'b0,3'd0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,8'h00,1'b1},
    '{1'b0,4'hD,1'b0,3'd0,2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h02,1'b1},
    '{1'b0,4'hD,1'b0,3'd2,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h12,1'b1},
    '{1'b0,4'hD,1'b0,3'd2,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h10,8'h12,1'b0},
    '{1'b0,4'hD,1'b0,3'd2,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h32,1'b0},
    '{1'b0,4'hD,1'b0,3'd2,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h32,1'b0},
    '{1'b0,4'hD,1'b0,3'd2,2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h72,1'b0},
    '{1'b0,4'hD,1'b0,3'd2,2'd1,1'b1,1'b1,1'b0,1'b1,1'b0,8'h00,8'h00,1'b1},
    '{1'b1,4'hD,1'b0,3'd2,2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'hC0,1'b1},
    '{1'b1,4'hD,1'b0,3'd2,2'd1,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,8'h80,1'b1},
    '{1'b1,4'hD,1'b0,3'd2,2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h80,1'b1},
    '{1'b1,4'hD,1'b0,3'd2,2'd2,1'b0,1'b1,1'b0,1'b0,1'b1,8'h80,8'h80,1'b0},
    '{1'b1,4'hD,1'b0,3'd2,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b1},
    '{1'b1,4'hD,1'b0,3'd5,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,8'h50,1'b1}
  };
  localparam string TAG [NROW] = '{
    "R11", "R1", "R1", "R1", "R5", "R3", "R2", "R1", "R11", "R7",
    "R7", "R4", "R3", "R6", "R6", "R7", "R8", "R6", "R10"
  };

  logic       clk;
  logic       rst_n;
  logic       manual_mode;
  logic [3:0] ref_ok;
  logic       better_ref_p;
  logic       xref_active;
  logic [2:0] dpll_mode;
  logic [1:0] active_sel;
  logic       los;
  logic       lol;
  logic       evt_rd;
  logic [7:0] evt_o;
  logic       en_wr;
  logic [7:0] en_wdata;
  logic       irq_n;
  int         n_run;
  int         n_fail;

  sync_evt_irq u0 (
    .clk(clk), .rst_n(rst_n), .manual_mode(manual_mode), .ref_ok(ref_ok),
    .better_ref_p(better_ref_p), .xref_active(xref_active),
    .dpll_mode(dpll_mode), .active_sel(active_sel), .los(los), .lol(lol),
    .evt_rd(evt_rd), .evt_o(evt_o), .en_wr(en_wr), .en_wdata(en_wdata),
    .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] xe, input logic xi);
    n_run++;
    if (evt_o !== xe || irq_n !== xi) begin
      n_fail++;
      $display("FAIL %s: evt=%02h irq_n=%b expected evt=%02h irq_n=%b",
               req, evt_o, irq_n, xe, xi);
    end
  endtask

  task automatic clear_strobes();
    better_ref_p = 1'b0;
    evt_rd       = 1'b0;
    en_wr        = 1'b0;
    en_wdata     = 8'h00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    manual_mode = 1'b0;
    ref_ok = 4'h0;
    xref_active = 1'b0;
    dpll_mode = 3'd0;
    active_sel = 2'd0;
    los = 1'b0;
    lol = 1'b0;
    clear_strobes();
    repeat (2) @(negedge clk);
    check("R8", 8'h00, 1'b1);              // reset state
    rst_n = 1'b1;
    tick();                                // priming edge

    for (int i = 0; i < NROW; i++) begin
      manual_mode  = TBL[i].man;
      ref_ok       = TBL[i].rok;
      xref_active  = TBL[i].xr;
      dpll_mode    = TBL[i].md;
      active_sel   = TBL[i].sl;
      los          = TBL[i].ls;
      lol          = TBL[i].ll;
      better_ref_p = TBL[i].bt;
      evt_rd       = TBL[i].rd;
      en_wr        = TBL[i].ew;
      en_wdata     = TBL[i].ewd;
      tick();
      check(TAG[i], TBL[i].xe, TBL[i].xi);
    end
    clear_strobes();

    // R7: holdoff window boundary after an automatic switch (enables = 0x80)
    manual_mode = 1'b0;
    evt_rd = 1'b1;
    tick();
    evt_rd = 1'b0;
    check("R7", 8'h00, 1'b1);
    active_sel = 2'd3;
    tick();                                // switch edge
    check("R7", 8'h20, 1'b1);
    evt_rd = 1'b1;
    tick();                                // first holdoff cycle
    evt_rd = 1'b0;
    repeat (14) tick();
    lol = 1'b1;
    tick();                                // 16th cycle after switch: suppressed
    check("R7", 8'h00, 1'b1);
    lol = 1'b0;
    tick();
    lol = 1'b1;
    tick();                                // past the window: recorded
    check("R7", 8'h80, 1'b0);

    // R9: levels held through reset raise nothing; enables cleared by reset
    rst_n = 1'b0;
    xref_active = 1'b1;
    ref_ok = 4'hF;
    los = 1'b1;
    lol = 1'b1;
    dpll_mode = 3'd6;
    @(negedge clk);
    check("R8", 8'h00, 1'b1);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R9", 8'h00, 1'b1);
    xref_active = 1'b0;
    tick();
    check("R2", 8'h04, 1'b1);              // latched though not enabled
    en_wr = 1'b1;
    en_wdata = 8'h04;
    tick();
    clear_strobes();
    check("R11", 8'h04, 1'b0);
    evt_rd = 1'b1;
    tick();
    clear_strobes();
    check("R3", 8'h00, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule